// File: doc/BRIEF.md
# Lane-Partitioned Saturating Add/Subtract Unit

This unit adds or subtracts two 64-bit words as a vector of independent elements. A lane-size select cuts the word into eight 8-bit, four 16-bit or two 32-bit lanes. Carries never pass from one lane into the next. Subtraction inverts the second operand and injects a carry of one at the bottom of every lane. A signed/unsigned select picks how each lane is interpreted, and that choice decides what counts as overflow.

Each lane reports its own overflow. When saturation is enabled, a lane that overflows returns the representable extreme nearest the true result instead of the wrapped value. This suits media kernels, where clipping is better than wrap-around. When saturation is off, every lane wraps modulo its width and the flags are still reported.

The result and the flags are registered. They appear one clock after the operands are presented, and no handshake is involved.

Top module: `psat_adder`

## Requirements
- R1: While reset is asserted, the result is zero and all eight overflow flags are zero.
- R2: Lane-size code 0 selects 8-bit lanes, code 1 selects 16-bit lanes, and codes 2 and 3 select 32-bit lanes. No carry crosses a lane boundary in any mode.
- R3: With saturation off, each lane of an add holds (a + b) modulo 2^W, where W is the lane width.
- R4: A subtract yields (a - b) modulo 2^W in every lane, computed as a plus the inverse of b plus one per lane.
- R5: In unsigned mode a lane overflows when an add carries out of the lane's top bit, or when a subtract borrows (a < b).
- R6: In signed mode an add overflows only when both operands share a sign and the result sign differs. A subtract overflows only when a negative minus a positive gives sign 0, or a positive minus a negative gives sign 1.
- R7: There is one flag per byte position (bit i covers bits 8i+7..8i). A lane's flag appears on its most significant byte position, and the other flag bits in that lane are zero.
- R8: With saturation on in unsigned mode, an overflowing add lane becomes all ones and an overflowing subtract lane becomes zero.
- R9: With saturation on in signed mode, positive overflow gives 0111…1 and negative overflow gives 1000…0 for that lane width.
- R10: The result and flags for operands presented before a rising clock edge appear right after that edge and hold until the next one.
- R11: Overflow flags are produced whether or not saturation is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_a_i | input | 64 | First operand |
| op_b_i | input | 64 | Second operand (subtrahend when subtracting) |
| lane_mode_i | input | 2 | Lane size: 0 = 8-bit, 1 = 16-bit, 2 or 3 = 32-bit |
| sub_i | input | 1 | 1 = subtract, 0 = add |
| signed_i | input | 1 | 1 = two's complement lanes, 0 = unsigned lanes |
| sat_i | input | 1 | 1 = clamp overflowing lanes, 0 = wrap |
| sum_o | output | 64 | Registered lane results |
| ovf_o | output | 8 | Registered overflow flags, one per byte position |

## Verification
The only state is the output register, so a corrupted carry cut, lane-end decode or clamp select shows up in the very next cycle as a wrong byte in sum_o or a stray bit in ovf_o. A carry leaking across a lane boundary disturbs the neighbouring lane's low bits. A misplaced lane-end decode moves or duplicates a flag. Both show up on any vector whose lower lane carries out. The bench therefore compares every cycle against a lane-by-lane integer model and drives the carry-out and sign-change corners in every mode.

// File: rtl/psat_pkg.sv
package psat_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        LANE_B8  = 2'd0,
        LANE_H16 = 2'd1,
        LANE_W32 = 2'd2,
        LANE_W32X = 2'd3
    } lane_mode_e;

    // index mask inside a lane: bytes per lane minus one
    function automatic logic [1:0] lane_mask(lane_mode_e m);
        unique case (m)
            LANE_B8:  lane_mask = 2'd0;
            LANE_H16: lane_mask = 2'd1;
            default:  lane_mask = 2'd3;
        endcase
    endfunction

endpackage

// File: rtl/psat_lane_ctrl.sv
module psat_lane_ctrl
    import psat_pkg::*;
#(
    parameter int NUM_BYTES = 8,
    localparam int IDX_W = $clog2(NUM_BYTES)
)(
    input  lane_mode_e           mode_i,
    output logic [NUM_BYTES-1:0] start_o,
    output logic [NUM_BYTES-1:0] end_o,
    output logic [IDX_W-1:0]     top_idx_o [NUM_BYTES]
);

    logic [IDX_W-1:0] mask;

    always_comb begin
        mask = IDX_W'(lane_mask(mode_i));
    end

    for (genvar i = 0; i < NUM_BYTES; i++) begin : g_byte
        localparam logic [IDX_W-1:0] POS = IDX_W'(i);
        always_comb begin
            start_o[i]   = ((POS & mask) == '0);
            end_o[i]     = ((POS & mask) == mask);
            top_idx_o[i] = POS | mask;
        end
    end

endmodule

// File: rtl/psat_byte_slice.sv
module psat_byte_slice
    import psat_pkg::*;
(
    input  logic [BYTE_W-1:0] a_i,
    input  logic [BYTE_W-1:0] b_i,
    input  logic              sub_i,
    input  logic              cin_i,
    output logic [BYTE_W-1:0] sum_o,
    output logic              cout_o,
    output logic              a_top_o,
    output logic              bx_top_o
);

    logic [BYTE_W-1:0] bx;

    always_comb begin
        bx = sub_i ? ~b_i : b_i;
        {cout_o, sum_o} = {1'b0, a_i} + {1'b0, bx} + {{BYTE_W{1'b0}}, cin_i};
        a_top_o  = a_i[BYTE_W-1];
        bx_top_o = bx[BYTE_W-1];
    end

endmodule

// File: rtl/psat_clamp.sv
module psat_clamp
    import psat_pkg::*;
(
    input  logic [BYTE_W-1:0] sum_i,
    input  logic              lane_ovf_i,
    input  logic              lane_pos_i,
    input  logic              is_top_i,
    input  logic              sat_i,
    input  logic              signed_i,
    input  logic              sub_i,
    output logic [BYTE_W-1:0] byte_o
);

    localparam logic [BYTE_W-1:0] ONES = '1;
    localparam logic [BYTE_W-1:0] ZERO = '0;
    localparam logic [BYTE_W-1:0] SMAX = {1'b0, {(BYTE_W-1){1'b1}}};
    localparam logic [BYTE_W-1:0] SMIN = {1'b1, {(BYTE_W-1){1'b0}}};

    always_comb begin
        if (!(sat_i && lane_ovf_i)) begin
            byte_o = sum_i;
        end else if (!signed_i) begin
            byte_o = sub_i ? ZERO : ONES;
        end else if (lane_pos_i) begin
            byte_o = is_top_i ? SMAX : ONES;
        end else begin
            byte_o = is_top_i ? SMIN : ZERO;
        end
    end

endmodule

// File: rtl/psat_adder.sv
module psat_adder
    import psat_pkg::*;
#(
    parameter int NUM_BYTES = 8,
    localparam int DATA_W = NUM_BYTES * BYTE_W,
    localparam int IDX_W = $clog2(NUM_BYTES)
)(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [DATA_W-1:0]    op_a_i,
    input  logic [DATA_W-1:0]    op_b_i,
    input  logic [1:0]           lane_mode_i,
    input  logic                 sub_i,
    input  logic                 signed_i,
    input  logic                 sat_i,
    output logic [DATA_W-1:0]    sum_o,
    output logic [NUM_BYTES-1:0] ovf_o
);

    lane_mode_e mode;
    logic [NUM_BYTES-1:0] start_b, end_b, cin_b, cout_b, a_top, bx_top, lane_ovf;
    logic [IDX_W-1:0]     top_idx [NUM_BYTES];
    logic [BYTE_W-1:0]    raw_sum [NUM_BYTES];
    logic [BYTE_W-1:0]    out_byte [NUM_BYTES];
    logic [DATA_W-1:0]    sum_d;

    always_comb begin
        mode = lane_mode_e'(lane_mode_i);
    end

    psat_lane_ctrl #(.NUM_BYTES(NUM_BYTES)) u_ctrl (
        .mode_i    (mode),
        .start_o   (start_b),
        .end_o     (end_b),
        .top_idx_o (top_idx)
    );

    for (genvar i = 0; i < NUM_BYTES; i++) begin : g_slice
        if (i == 0) begin : g_first
            always_comb cin_b[i] = sub_i;
        end else begin : g_rest
            always_comb cin_b[i] = start_b[i] ? sub_i : cout_b[i-1];
        end

        psat_byte_slice u_slice (
            .a_i      (op_a_i[i*BYTE_W +: BYTE_W]),
            .b_i      (op_b_i[i*BYTE_W +: BYTE_W]),
            .sub_i    (sub_i),
            .cin_i    (cin_b[i]),
            .sum_o    (raw_sum[i]),
            .cout_o   (cout_b[i]),
            .a_top_o  (a_top[i]),
            .bx_top_o (bx_top[i])
        );

        logic u_ovf, s_ovf;
        always_comb begin
            u_ovf = sub_i ? ~cout_b[i] : cout_b[i];
            s_ovf = (a_top[i] == bx_top[i]) && (raw_sum[i][BYTE_W-1] != a_top[i]);
            lane_ovf[i] = end_b[i] && (signed_i ? s_ovf : u_ovf);
        end
    end

    for (genvar i = 0; i < NUM_BYTES; i++) begin : g_sat
        logic own_ovf, own_pos;
        always_comb begin
            own_ovf = lane_ovf[top_idx[i]];
            own_pos = ~a_top[top_idx[i]];
        end

        psat_clamp u_clamp (
            .sum_i      (raw_sum[i]),
            .lane_ovf_i (own_ovf),
            .lane_pos_i (own_pos),
            .is_top_i   (end_b[i]),
            .sat_i      (sat_i),
            .signed_i   (signed_i),
            .sub_i      (sub_i),
            .byte_o     (out_byte[i])
        );

        always_comb sum_d[i*BYTE_W +: BYTE_W] = out_byte[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sum_o <= '0;
            ovf_o <= '0;
        end else begin
            sum_o <= sum_d;
            ovf_o <= lane_ovf;
        end
    end

    for (genvar i = 0; i < NUM_BYTES; i++) begin : g_chk
        if (i % 2 == 0) begin : g_even
            // R7
            flag_even_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (lane_mode_i != 2'd0) |=> !ovf_o[i]);
        end
        if (i % 4 != 3) begin : g_nontop
            // R7
            flag_wide_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (lane_mode_i[1]) |=> !ovf_o[i]);
        end
        // R3
        wrap_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!sat_i && lane_mode_i == 2'd0 && !sub_i) |=>
            (sum_o[i*BYTE_W +: BYTE_W] ==
             BYTE_W'($past(op_a_i[i*BYTE_W +: BYTE_W]) + $past(op_b_i[i*BYTE_W +: BYTE_W]))));
        // R8
        usat_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (sat_i && !signed_i) |=>
            (!ovf_o[i] || sum_o[i*BYTE_W +: BYTE_W] == ($past(sub_i) ? 8'h00 : 8'hFF)));
        // R9
        ssat_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (sat_i && signed_i) |=>
            (!ovf_o[i] || sum_o[i*BYTE_W +: BYTE_W] == 8'h7F || sum_o[i*BYTE_W +: BYTE_W] == 8'h80));
    end

endmodule

// File: tb/psat_adder_bench.sv
`timescale 1ns/1ps
module psat_adder_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] a = '0, b = '0;
    logic [1:0]  mode = '0;
    logic        sub = 1'b0, sgn = 1'b0, sat = 1'b0;
    logic [63:0] sum_o;
    logic [7:0]  ovf_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    bit          pending = 1'b0;
    logic [63:0] exp_r;
    logic [7:0]  exp_f, top_mask;
    string       tag_r, tag_f;

    always #2.5 clk = ~clk;

    psat_adder u_psat_adder (
        .clk(clk), .rst_n(rst_n), .op_a_i(a), .op_b_i(b), .lane_mode_i(mode),
        .sub_i(sub), .signed_i(sgn), .sat_i(sat), .sum_o(sum_o), .ovf_o(ovf_o)
    );

    function automatic void model(input logic [63:0] x, input logic [63:0] y,
                                  input int md, input bit s, input bit sg, input bit st,
                                  output logic [63:0] r, output logic [7:0] f,
                                  output logic [7:0] tm);
        int lb;
        int w;
        longint span;
        lb = (md == 0) ? 1 : (md == 1) ? 2 : 4;
        w = lb * 8;
        span = longint'(1) << w;
        r = '0; f = '0; tm = '0;
        for (int l = 0; l < 8 / lb; l++) begin
            longint ua, ub, va, vb, ex, lo, hi, v;
            bit ov;
            ua = longint'((x >> (l * w)) & 64'(span - 1));
            ub = longint'((y >> (l * w)) & 64'(span - 1));
            va = ua; vb = ub;
            if (sg && ua >= span / 2) va = ua - span;
            if (sg && ub >= span / 2) vb = ub - span;
            ex = s ? va - vb : va + vb;
            lo = sg ? -(span / 2) : 0;
            hi = sg ? span / 2 - 1 : span - 1;
            ov = (ex < lo) || (ex > hi);
            v = ex;
            if (ov && st) v = (ex < lo) ? lo : hi;
            v = v & (span - 1);
            r = r | (64'(v) << (l * w));
            tm[l * lb + lb - 1] = 1'b1;
            if (ov) f[l * lb + lb - 1] = 1'b1;
        end
    endfunction

    task automatic check_pending();
        if (pending) begin
            checks++;
            if (sum_o !== exp_r) begin
                failures++;
                $display("FAIL %s result actual=%h expected=%h", tag_r, sum_o, exp_r);
            end
            checks++;
            if (ovf_o !== exp_f) begin
                failures++;
                $display("FAIL %s flags actual=%b expected=%b", tag_f, ovf_o, exp_f);
            end
            // R7: no flag outside the lane's top byte
            checks++;
            if ((ovf_o & ~top_mask) !== 8'h00) begin
                failures++;
                $display("FAIL R7 stray flags actual=%b expected=%b", ovf_o & ~top_mask, 8'h00);
            end
        end
    endtask

    task automatic step(input logic [63:0] x, input logic [63:0] y, input int md,
                        input bit s, input bit sg, input bit st,
                        input string tr, input string tf);
        @(negedge clk);
        check_pending();
        a = x; b = y; mode = 2'(md); sub = s; sgn = sg; sat = st;
        model(x, y, md, s, sg, st, exp_r, exp_f, top_mask);
        if (tr != "") tag_r = tr;
        else if (st && exp_f != 0) tag_r = sg ? "R9" : "R8";
        else tag_r = s ? "R4" : "R3";
        if (tf != "") tag_f = tf;
        else tag_f = sg ? "R6" : "R5";
        pending = 1'b1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        checks++;
        if (sum_o !== 64'h0 || ovf_o !== 8'h0) begin
            failures++;
            $display("FAIL R1 reset actual=%h/%b expected=0/0", sum_o, ovf_o);
        end
        rst_n = 1'b1;

        // R8: unsigned byte add saturates to FF
        step(64'hFFFF_FFFF_FFFF_FFFF, 64'h0101_0101_0101_0101, 0, 0, 0, 1, "R8", "R5");
        // R11: same vector wraps, flags still reported
        step(64'hFFFF_FFFF_FFFF_FFFF, 64'h0101_0101_0101_0101, 0, 0, 0, 0, "R3", "R11");
        // R2: carry out of byte 0 must not reach byte 1
        step(64'h0000_0000_0000_00FF, 64'h0000_0000_0000_0001, 0, 0, 0, 0, "R2", "R5");
        // R2: same in 16-bit mode carries into byte 1
        step(64'h0000_0000_0000_00FF, 64'h0000_0000_0000_0001, 1, 0, 0, 0, "R2", "R5");
        // R9: signed 16-bit positive overflow clamps to 7FFF
        step(64'h7FFF_7FFF_0001_7FFF, 64'h0001_0001_0001_0001, 1, 0, 1, 1, "R9", "R6");
        // R9: signed 32-bit negative overflow on subtract clamps to 80000000
        step(64'h8000_0000_0000_0005, 64'h0000_0001_0000_0003, 2, 1, 1, 1, "R9", "R6");
        // R6: positive minus negative overflows upward
        step(64'h7F00_0000_0000_007F, 64'h8100_0000_0000_00FF, 0, 1, 1, 1, "R9", "R6");
        // R8: unsigned subtract borrow clamps to zero
        step(64'h0000_0000_0000_0000, 64'h0101_0101_0101_0101, 0, 1, 0, 1, "R8", "R5");
        // R4: wrapped subtract, borrow per lane
        step(64'h0000_1234_0000_0010, 64'h0001_0001_0000_0020, 1, 1, 0, 0, "R4", "R5");
        // R2: code 3 behaves as 32-bit lanes
        step(64'h0000_00FF_FFFF_FFFF, 64'h0000_0001_0000_0001, 3, 0, 0, 0, "R2", "R5");
        // R10: back-to-back vectors each appear one edge later
        step(64'h0102_0304_0506_0708, 64'h1010_1010_1010_1010, 0, 0, 0, 0, "R10", "R10");
        step(64'h8080_8080_8080_8080, 64'h8080_8080_8080_8080, 0, 0, 1, 0, "R10", "R6");

        for (int k = 0; k < 3000; k++) begin
            logic [63:0] x, y;
            x = {$urandom, $urandom};
            y = {$urandom, $urandom};
            if (k % 5 == 0) y = ~x;
            step(x, y, int'($urandom % 4), 1'($urandom), 1'($urandom), 1'($urandom), "", "");
        end
        @(negedge clk);
        check_pending();
        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule